// File: doc/BRIEF.md
# Bus Ownership Arbitration Controller

This block sits on the bus-owner side of a three-wire request, grant and acknowledge handshake. An outside master raises a request. The controller answers with a grant once it is safe to do so. The outside master then raises an acknowledge and holds the bus for as long as that acknowledge stays high. Request and acknowledge arrive with no fixed timing relation to the clock, so each one passes through a two-flop synchronizer before the state machine acts on it.

The controller also watches three status lines from the owner's own bus engine:
- the address strobe;
- the read-modify-write lock;
- a flag that says a further bus cycle has already been decided but has not yet begun.

While the lock is held, or while a decided cycle is still waiting to start, no grant is issued.

After the acknowledge is seen, the grant drops and a float enable rises. One edge after the strobe and the lock are both low, the float enable is turned into a registered release signal for the pad drivers. If the request is still high while the acknowledge is held, a fresh grant is issued. A hold-off line keeps the owner's engine from starting any cycle while the grant or the float enable is high.

Top module: `bus_arbiter_ctl`

## Requirements
- R1: A change on the request input reaches the state machine through exactly two synchronizer flops. A request raised between edges therefore shows on `grant` right after the third rising edge that follows.
- R2: While `lock_active` is 1, `grant` is never raised from the idle, owner-held state.
- R3: While `cycle_pending` is 1, `grant` is never raised from the idle state. It is raised on the first edge after the pending flag falls.
- R4: From idle, with the synchronized request at 1, `lock_active` at 0 and `cycle_pending` at 0, `grant` rises on the next edge.
- R5: When the synchronized acknowledge is seen while granted, `grant` falls and `float_en` rises on the same edge. `float_en` stays at 1 while the synchronized acknowledge stays at 1.
- R6: While the acknowledge is held and the synchronized request is still at 1, `grant` is raised again on the next edge, and `float_en` stays at 1.
- R7: `bus_hiz` is 1 after an edge exactly when, just before that edge, `float_en` was 1 and both `strobe_active` and `lock_active` were 0.
- R8: When the synchronized acknowledge falls, `float_en` falls on the next edge. If the synchronized request is also 0, the block returns to idle with `grant` at 0.
- R9: `hold_off` is 1 whenever `grant` or `float_en` is 1, and 0 otherwise.
- R10: While `rst_n` is 0, `grant`, `float_en`, `bus_hiz` and `hold_off` are all 0, and the synchronizer flops are cleared.
- R11: If the synchronized request falls while granted and before any acknowledge, `grant` falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_async | input | 1 | Bus request from the outside master, unsynchronized |
| ack_async | input | 1 | Acknowledge from the outside master, unsynchronized |
| strobe_active | input | 1 | The owner's address strobe is active |
| lock_active | input | 1 | A read-modify-write lock is in progress |
| cycle_pending | input | 1 | A further owner cycle has been decided but has not yet begun |
| grant | output | 1 | Bus grant to the outside master |
| float_en | output | 1 | Float enable: the outside master owns the bus |
| bus_hiz | output | 1 | Registered release for the address, data and control drivers |
| hold_off | output | 1 | Tells the owner's bus engine to start no new cycle |

## Verification
The bench counts edges from a request to the grant. A design that added or dropped a synchronizer stage would shift the grant by one cycle. Requests are held against an active lock and against a pending cycle. A design that ignored either input would grant early, in the middle of an atomic sequence.

The re-grant path keeps the request high through the acknowledge. A design that lost this path would leave `grant` low, or would drop `float_en` between grants.

The release register is tested with the strobe held active. A design that did not register the release, or that ignored the strobe, would float the pads one cycle early or in the middle of a cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_OWN    = 2'd0,  // processor owns the bus, no grant
    ST_OFFER  = 2'd1,  // grant out, waiting for acknowledge
    ST_LENT   = 2'd2,  // acknowledged, other master owns the bus
    ST_REOFFER = 2'd3  // still lent, fresh grant out for a pending request
  } arb_state_t;

  function automatic logic grant_of(arb_state_t s);
    return (s == ST_OFFER) || (s == ST_REOFFER);
  endfunction

  function automatic logic float_of(arb_state_t s);
    return (s == ST_LENT) || (s == ST_REOFFER);
  endfunction

  // an idle owner may offer the bus only with no atomic sequence and no decided cycle
  function automatic logic may_offer(logic req, logic lock, logic pend);
    return req && !lock && !pend;
  endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[LAST];
  end

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic ack_s,
  input  logic lock_active,
  input  logic cycle_pending,
  output logic grant,
  output logic float_en
);

  arb_state_t state, state_nx;

  // named events for the assertions
  logic idle_blocked;
  logic ack_seen_offer;
  logic lent_req_again;
  logic ack_gone;

  assign idle_blocked   = (state == ST_OWN) && (lock_active || cycle_pending);
  assign ack_seen_offer = (state == ST_OFFER) && ack_s;
  assign lent_req_again = (state == ST_LENT) && ack_s && req_s;
  assign ack_gone       = float_of(state) && !ack_s;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_OWN:
        if (may_offer(req_s, lock_active, cycle_pending)) state_nx = ST_OFFER;
      ST_OFFER:
        if (ack_s)       state_nx = ST_LENT;
        else if (!req_s) state_nx = ST_OWN;
      ST_LENT:
        if (!ack_s)      state_nx = req_s ? ST_OFFER : ST_OWN;
        else if (req_s)  state_nx = ST_REOFFER;
      ST_REOFFER:
        if (!ack_s)      state_nx = req_s ? ST_OFFER : ST_OWN;
      default:           state_nx = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OWN;
    else        state <= state_nx;
  end

  assign grant    = grant_of(state);
  assign float_en = float_of(state);

  AST_NO_GRANT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    idle_blocked && lock_active |=> !grant);  // R2
  AST_NO_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    idle_blocked && cycle_pending |=> !grant);  // R3
  AST_ACK_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen_offer |=> (!grant && float_en));  // R5
  AST_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    lent_req_again |=> (grant && float_en));  // R6
  AST_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ack_gone |=> !float_en);  // R8

endmodule

// File: rtl/arb_release.sv
module arb_release (
  input  logic clk,
  input  logic rst_n,
  input  logic float_en,
  input  logic strobe_active,
  input  logic lock_active,
  output logic bus_hiz
);

  logic bus_quiet;
  assign bus_quiet = !strobe_active && !lock_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_hiz <= 1'b0;
    else        bus_hiz <= float_en && bus_quiet;
  end

  AST_HIZ_WAITS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_quiet |=> !bus_hiz);  // R7
  AST_HIZ_NEEDS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !float_en |=> !bus_hiz);  // R7

endmodule

// File: rtl/bus_arbiter_ctl.sv
module bus_arbiter_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  input  logic ack_async,
  input  logic strobe_active,
  input  logic lock_active,
  input  logic cycle_pending,
  output logic grant,
  output logic float_en,
  output logic bus_hiz,
  output logic hold_off
);

  localparam int NSIG = 2;

  logic [NSIG-1:0] raw_in;
  logic [NSIG-1:0] synced;
  logic            req_s;
  logic            ack_s;

  assign raw_in = {ack_async, req_async};

  arb_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .q_sync  (synced)
  );

  assign req_s = synced[0];
  assign ack_s = synced[1];

  arb_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_s         (req_s),
    .ack_s         (ack_s),
    .lock_active   (lock_active),
    .cycle_pending (cycle_pending),
    .grant         (grant),
    .float_en      (float_en)
  );

  arb_release u_rel (
    .clk           (clk),
    .rst_n         (rst_n),
    .float_en      (float_en),
    .strobe_active (strobe_active),
    .lock_active   (lock_active),
    .bus_hiz       (bus_hiz)
  );

  assign hold_off = grant | float_en;

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(req_s));  // R4
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !float_en && !req_s && !ack_s) |=> !grant);  // R11

endmodule

// File: tb/bus_arbiter_ctl_tb.sv
module bus_arbiter_ctl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_async = 0, ack_async = 0, strobe_active = 0, lock_active = 0, cycle_pending = 0;
  logic grant, float_en, bus_hiz, hold_off;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  bus_arbiter_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_async(req_async), .ack_async(ack_async),
    .strobe_active(strobe_active), .lock_active(lock_active),
    .cycle_pending(cycle_pending), .grant(grant), .float_en(float_en),
    .bus_hiz(bus_hiz), .hold_off(hold_off)
  );

  // bench model: 0 own, 1 offered, 2 lent, 3 lent with new offer
  int  m_st = 0;
  logic m_s1r = 0, m_s1a = 0, m_r = 0, m_a = 0, m_hiz = 0;

  function automatic logic exp_grant(int s); return s == 1 || s == 3; endfunction
  function automatic logic exp_float(int s); return s >= 2; endfunction

  task automatic model_edge();
    int  nx;
    logic flt_old;
    flt_old = exp_float(m_st);
    nx = m_st;
    case (m_st)
      0: if (m_r && !lock_active && !cycle_pending) nx = 1;
      1: if (m_a) nx = 2; else if (!m_r) nx = 0;
      2: if (!m_a) nx = m_r ? 1 : 0; else if (m_r) nx = 3;
      default: if (!m_a) nx = m_r ? 1 : 0;
    endcase
    m_hiz = flt_old && !strobe_active && !lock_active;
    m_st = nx;
    m_r = m_s1r; m_a = m_s1a;
    m_s1r = req_async; m_s1a = ack_async;
  endtask

  task automatic chk(string tag, string what, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4", "grant", grant, exp_grant(m_st));
    chk("R5", "float_en", float_en, exp_float(m_st));
    chk("R7", "bus_hiz", bus_hiz, m_hiz);
    chk("R9", "hold_off", hold_off, exp_grant(m_st) | exp_float(m_st));
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    req_async = 0; ack_async = 0; strobe_active = 0; lock_active = 0; cycle_pending = 0;
    m_st = 0; m_s1r = 0; m_s1a = 0; m_r = 0; m_a = 0; m_hiz = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h1357;
    void'($urandom(seed));
    rst_n = 0;
    repeat (2) @(negedge clk);
    // R10 reset state
    req_async = 1; ack_async = 1;
    @(negedge clk);
    chk("R10", "grant in reset", grant, 0);
    chk("R10", "float_en in reset", float_en, 0);
    chk("R10", "bus_hiz in reset", bus_hiz, 0);
    chk("R10", "hold_off in reset", hold_off, 0);
    do_reset();

    // R1 latency, R4 grant from idle
    req_async = 1;
    tick(2);
    chk("R1", "grant before third edge", grant, 0);
    tick(1);
    chk("R1", "grant after third edge", grant, 1);
    chk("R4", "grant from idle", grant, 1);
    // R5 acknowledge: grant drops, float rises; strobe held to test R7
    strobe_active = 1;
    ack_async = 1;
    tick(3);
    chk("R5", "float after ack", float_en, 1);
    // request still high -> R6 re-grant next edge
    tick(1);
    chk("R6", "regrant", grant, 1);
    chk("R6", "float kept", float_en, 1);
    chk("R7", "no hiz while strobe", bus_hiz, 0);
    strobe_active = 0;
    tick(1);
    chk("R7", "hiz after quiet edge", bus_hiz, 1);
    // R8 release
    req_async = 0; ack_async = 0;
    tick(3);
    chk("R8", "float drops", float_en, 0);
    chk("R8", "back to idle", grant, 0);
    tick(1);
    chk("R7", "hiz follows float", bus_hiz, 0);

    // R2 lock blocks grant
    lock_active = 1; req_async = 1;
    tick(6);
    chk("R2", "no grant while locked", grant, 0);
    lock_active = 0;
    tick(1);
    chk("R2", "grant after unlock", grant, 1);
    // R11 withdrawal
    req_async = 0;
    tick(2);
    chk("R11", "grant held until sync", grant, 1);
    tick(1);
    chk("R11", "grant withdrawn", grant, 0);

    // R3 pending cycle blocks grant
    cycle_pending = 1; req_async = 1;
    tick(6);
    chk("R3", "no grant while pending", grant, 0);
    chk("R9", "engine free", hold_off, 0);
    cycle_pending = 0;
    tick(1);
    chk("R3", "grant after cycle began", grant, 1);
    chk("R9", "engine held", hold_off, 1);
    req_async = 0;
    tick(4);

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) req_async = ~req_async;
      if ($urandom_range(0, 11) == 0) ack_async = ~ack_async;
      strobe_active = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 7) == 0) lock_active = ~lock_active;
      cycle_pending = ($urandom_range(0, 4) == 0);
      tick(1);
      if (i == 2000) do_reset();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule